// File: doc/BRIEF.md
# SM3 Streaming Hash Engine

This block computes the 256-bit SM3 digest of a message of any byte length. The message arrives as a stream of 512-bit beats, and each beat is exactly one compression block. The last beat of a message carries a flag and a per-byte keep mask that says how many of its bytes belong to the message. The engine keeps a running bit count across the beats. It adds the SM3 padding itself, so the sender never builds padding blocks. It expands each block into the message schedule, runs the compression rounds, and chains each result into the state for the next block. When the final block has been folded in, it presents the digest together with a single-cycle valid strobe.

The input is a valid/ready stream, and a beat moves on any rising edge where both are high. Back-pressure rules: ready is high only while the engine is idle. Ready drops in the cycle after any beat is accepted and stays low for the whole compression of that block. After a non-final beat, ready comes back when that block's rounds finish. After a final beat, ready stays low through the padding work and comes back in the same cycle as the digest strobe. The sender must hold its beat stable while valid is high and ready is low. The digest output has no back-pressure, and the value on it is held until the next digest replaces it.

With the default setting of two rounds per clock, one block takes 32 cycles. When the final beat leaves too little room for the length field, the engine generates one extra padding-only block internally, and that costs another 32 cycles.

Top module: `sm3_stream_hash`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1 and `dig_valid` is 0.
- R2: A non-final beat accepted on edge e keeps `in_ready` low for exactly 32 cycles, and `in_ready` is high again after edge e+32.
- R3: The digest equals the SM3 hash of the message bytes, with `dig_data[255:224]` as the first digest word. Byte 0 of a beat is `in_data[511:504]` and byte i is `in_data[511-8i -: 8]`. On the final beat, keep bit i covers byte i and the set bits are contiguous from bit 0. Bytes outside the keep mask have no effect on the digest.
- R4: Messages longer than 64 bytes are hashed correctly, with each block's chaining value fed into the next block.
- R5: Let n be the number of bytes in the final beat. If n ≤ 55, `dig_valid` rises 32 cycles after that beat is accepted. If n ≥ 56, one extra internal padding block is compressed and `dig_valid` rises 64 cycles after the beat is accepted.
- R6: `dig_valid` is high for exactly one cycle per message, and `dig_data` changes only in a cycle where `dig_valid` is high.
- R7: After a digest is produced, the next message starts again from the SM3 initial vector and a zero length, so hashing the same message twice gives the same digest.
- R8: On non-final beats, `in_keep` is ignored and all 64 bytes are hashed.
- R9: A final beat with `in_keep` all zero, sent as the only beat, produces the digest of the empty message.
- R10: From the acceptance of a final beat until the digest strobe, `in_ready` stays low. It is high in the cycle where `dig_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Engine idle and able to take a beat |
| in_data | input | 512 | One message block, byte 0 in bits 511:504 |
| in_keep | input | 64 | Byte-valid mask for the final beat, bit i covers byte i |
| in_last | input | 1 | Marks the final beat of a message |
| dig_valid | output | 1 | One-cycle strobe qualifying the digest |
| dig_data | output | 256 | Digest, first word in bits 255:224 |

## Verification
The bench targets the padding boundary at 55, 56, 63 and 64 final-beat bytes. A design that misplaces the split either overwrites the length field or skips the extra block, and the digest or the 32/64-cycle latency comes out wrong. Random garbage sits outside the keep mask on final beats and inside the ignored mask on non-final beats. A design that honours the mask where it should not, or ignores it where it should not, produces a wrong digest. The empty message and a repeated identical message catch a length counter or chaining state that is not cleared between messages. A fixed reference value for "abc" anchors the bench's own model.

// File: rtl/sm3_pkg.sv
package sm3_pkg;

  typedef logic [31:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } st_t;

  localparam logic [255:0] SM3_IV = {
    32'h7380166f, 32'h4914b2b9, 32'h172442d7, 32'hda8a0600,
    32'ha96f30bc, 32'h163138aa, 32'he38dee4d, 32'hb0fb0e4e
  };

  localparam word_t T_EARLY = 32'h79cc4519;
  localparam word_t T_LATE  = 32'h7a879d8a;

  function automatic word_t rotl(input word_t x, input logic [4:0] s);
    word_t r;
    if (s == 5'd0) r = x;
    else           r = (x << s) | (x >> (6'd32 - {1'b0, s}));
    return r;
  endfunction

  function automatic word_t perm0(input word_t x);
    return x ^ rotl(x, 5'd9) ^ rotl(x, 5'd17);
  endfunction

  function automatic word_t perm1(input word_t x);
    return x ^ rotl(x, 5'd15) ^ rotl(x, 5'd23);
  endfunction

  // One compression round at round index j.
  function automatic st_t sm3_step(input st_t s, input logic [5:0] j,
                                   input word_t w, input word_t wp);
    st_t   o;
    word_t a12, tj, ss1, ss2, fv, gv, tt1, tt2;
    a12 = rotl(s.a, 5'd12);
    tj  = (j < 6'd16) ? T_EARLY : T_LATE;
    ss1 = rotl(a12 + s.e + rotl(tj, j[4:0]), 5'd7);
    ss2 = ss1 ^ a12;
    if (j < 6'd16) begin
      fv = s.a ^ s.b ^ s.c;
      gv = s.e ^ s.f ^ s.g;
    end else begin
      fv = (s.a & s.b) | (s.a & s.c) | (s.b & s.c);
      gv = (s.e & s.f) | (~s.e & s.g);
    end
    tt1 = fv + s.d + ss2 + wp;
    tt2 = gv + s.h + ss1 + w;
    o.d = s.c;
    o.c = rotl(s.b, 5'd9);
    o.b = s.a;
    o.a = tt1;
    o.h = s.g;
    o.g = rotl(s.f, 5'd19);
    o.f = s.e;
    o.e = perm0(tt2);
    return o;
  endfunction

endpackage

// File: rtl/sm3_pad.sv
module sm3_pad (
  input  logic [511:0] blk_in,
  input  logic [63:0]  keep,
  input  logic         last,
  input  logic [63:0]  len_in,
  output logic [511:0] blk0,
  output logic [511:0] blk1,
  output logic         two,
  output logic [63:0]  len_out
);
  localparam int BYTES = 64;
  localparam int ROOM  = 55;

  logic [6:0] nbytes;
  logic [6:0] kcount;

  always_comb begin
    kcount = '0;
    for (int i = 0; i < BYTES; i++) kcount = kcount + 7'(keep[i]);
  end

  assign nbytes  = last ? kcount : 7'd64;
  assign len_out = len_in + {54'd0, nbytes, 3'b000};
  assign two     = last && (nbytes > 7'(ROOM));

  always_comb begin
    blk0 = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (i < int'(nbytes))       blk0[511-8*i -: 8] = blk_in[511-8*i -: 8];
      else if (i == int'(nbytes)) blk0[511-8*i -: 8] = 8'h80;
      else                        blk0[511-8*i -: 8] = 8'h00;
    end
    if (last && !two) blk0[63:0] = len_out;
  end

  always_comb begin
    blk1 = '0;
    if (nbytes == 7'd64) blk1[511:504] = 8'h80;
    blk1[63:0] = len_out;
  end

endmodule

// File: rtl/sm3_sched.sv
module sm3_sched #(
  parameter int RPC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [511:0]          load_blk,
  input  logic                  adv,
  output logic [RPC-1:0][31:0]  w,
  output logic [RPC-1:0][31:0]  wp
);
  import sm3_pkg::*;

  localparam int WIN = 16;
  localparam int EXT = WIN + RPC;

  word_t win [WIN];
  word_t ext [EXT];

  always_comb begin
    for (int i = 0; i < WIN; i++) ext[i] = win[i];
    for (int k = 0; k < RPC; k++) begin
      ext[WIN+k] = perm1(ext[k] ^ ext[k+7] ^ rotl(ext[k+13], 5'd15))
                   ^ rotl(ext[k+3], 5'd7) ^ ext[k+10];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < WIN; i++) win[i] <= load_blk[511-32*i -: 32];
    end else if (adv) begin
      for (int i = 0; i < WIN; i++) win[i] <= ext[i+RPC];
    end
  end

  for (genvar k = 0; k < RPC; k++) begin : g_tap
    assign w[k]  = win[k];
    assign wp[k] = win[k] ^ win[k+4];
  end

endmodule

// File: rtl/sm3_rounds.sv
module sm3_rounds #(
  parameter int RPC = 2
) (
  input  sm3_pkg::st_t          st_in,
  input  logic [5:0]            base_j,
  input  logic [RPC-1:0][31:0]  w,
  input  logic [RPC-1:0][31:0]  wp,
  output sm3_pkg::st_t          st_out
);
  import sm3_pkg::*;

  always_comb begin
    st_t s;
    s = st_in;
    for (int k = 0; k < RPC; k++) s = sm3_step(s, base_j + 6'(k), w[k], wp[k]);
    st_out = s;
  end

endmodule

// File: rtl/sm3_stream_hash.sv
module sm3_stream_hash
  import sm3_pkg::*;
#(
  parameter int RPC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [511:0] in_data,
  input  logic [63:0]  in_keep,
  input  logic         in_last,
  output logic         dig_valid,
  output logic [255:0] dig_data
);
  localparam int STEPS = 64 / RPC;
  localparam int SW    = $clog2(STEPS);

  typedef enum logic {S_IDLE, S_RUN} mode_t;

  mode_t              mode;
  logic [SW-1:0]      step;
  st_t                st, vreg, st_next, vnew;
  logic [63:0]        len_bits, len_next;
  logic [511:0]       blk0, blk1, pad2, sch_blk;
  logic               two, pad2_pend, fin_pend;
  logic               accept, last_step, sch_load, sch_adv;
  logic [5:0]         base_j;
  logic [RPC-1:0][31:0] w, wp;

  assign in_ready  = (mode == S_IDLE);
  assign accept    = in_valid && in_ready;
  assign last_step = (mode == S_RUN) && (step == SW'(STEPS - 1));
  assign base_j    = 6'(32'(step) * RPC);
  assign vnew      = st_t'(vreg ^ st_next);
  assign sch_load  = accept || (last_step && pad2_pend);
  assign sch_blk   = accept ? blk0 : pad2;
  assign sch_adv   = (mode == S_RUN);

  sm3_pad u_pad (
    .blk_in  (in_data),
    .keep    (in_keep),
    .last    (in_last),
    .len_in  (len_bits),
    .blk0    (blk0),
    .blk1    (blk1),
    .two     (two),
    .len_out (len_next)
  );

  sm3_sched #(.RPC(RPC)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sch_load),
    .load_blk (sch_blk),
    .adv      (sch_adv),
    .w        (w),
    .wp       (wp)
  );

  sm3_rounds #(.RPC(RPC)) u_rounds (
    .st_in  (st),
    .base_j (base_j),
    .w      (w),
    .wp     (wp),
    .st_out (st_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= S_IDLE;
      step      <= '0;
      st        <= '0;
      vreg      <= st_t'(SM3_IV);
      len_bits  <= '0;
      pad2      <= '0;
      pad2_pend <= 1'b0;
      fin_pend  <= 1'b0;
      dig_data  <= '0;
      dig_valid <= 1'b0;
    end else begin
      dig_valid <= 1'b0;
      if (accept) begin
        mode      <= S_RUN;
        step      <= '0;
        st        <= vreg;
        len_bits  <= len_next;
        pad2      <= blk1;
        pad2_pend <= two;
        fin_pend  <= in_last;
      end else if (mode == S_RUN) begin
        st   <= st_next;
        step <= step + 1'b1;
        if (last_step) begin
          step <= '0;
          if (pad2_pend) begin
            vreg      <= vnew;
            st        <= vnew;
            pad2_pend <= 1'b0;
          end else if (fin_pend) begin
            dig_data  <= vnew;
            dig_valid <= 1'b1;
            vreg      <= st_t'(SM3_IV);
            len_bits  <= '0;
            fin_pend  <= 1'b0;
            mode      <= S_IDLE;
          end else begin
            vreg <= vnew;
            mode <= S_IDLE;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sm3_stream_hash_chk.sv
module sm3_stream_hash_chk #(
  parameter int RPC = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_last,
  input logic         dig_valid,
  input logic [255:0] dig_data
);
  localparam int STEPS = 64 / RPC;

  logic        pend;
  logic [15:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (in_valid && in_ready && in_last) pend <= 1'b1;
      else if (dig_valid)                  pend <= 1'b0;
      busy_cnt <= in_ready ? 16'd0 : busy_cnt + 16'd1;
    end
  end

  AST_LAST_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);  // R10
  AST_BUSY_UNTIL_DIGEST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !dig_valid) |-> !in_ready);  // R10
  AST_DIGEST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |=> !dig_valid);  // R6
  AST_DIGEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dig_data) |-> dig_valid);  // R6
  AST_DIGEST_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> pend);  // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (busy_cnt < 16'(2 * STEPS)));  // R2

endmodule

bind sm3_stream_hash sm3_stream_hash_chk #(.RPC(RPC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .dig_valid (dig_valid),
  .dig_data  (dig_data)
);

// File: tb/sim_sm3_stream_hash.sv
module sim_sm3_stream_hash;

  typedef byte unsigned bq_t[$];

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [511:0] in_data;
  logic [63:0]  in_keep;
  logic         in_last;
  logic         dig_valid;
  logic [255:0] dig_data;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sm3_stream_hash u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_keep   (in_keep),
    .in_last   (in_last),
    .dig_valid (dig_valid),
    .dig_data  (dig_data)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int s = n % 32;
    if (s == 0) return x;
    return (x << s) | (x >> (32 - s));
  endfunction

  function automatic logic [255:0] ref_hash(input bq_t m);
    bq_t         p;
    logic [63:0] bl;
    logic [31:0] v [8];
    logic [31:0] w [68];
    logic [31:0] a, b, c, d, e, f, g, h, ss1, ss2, tt1, tt2, tj, x;
    p  = m;
    bl = 64'(m.size()) << 3;
    p.push_back(8'h80);
    while ((p.size() % 64) != 56) p.push_back(8'h00);
    for (int i = 0; i < 8; i++) p.push_back(bl[63-8*i -: 8]);
    v[0] = 32'h7380166f; v[1] = 32'h4914b2b9; v[2] = 32'h172442d7; v[3] = 32'hda8a0600;
    v[4] = 32'ha96f30bc; v[5] = 32'h163138aa; v[6] = 32'he38dee4d; v[7] = 32'hb0fb0e4e;
    for (int bk = 0; bk < p.size() / 64; bk++) begin
      for (int i = 0; i < 16; i++)
        w[i] = {p[bk*64+4*i], p[bk*64+4*i+1], p[bk*64+4*i+2], p[bk*64+4*i+3]};
      for (int i = 16; i < 68; i++) begin
        x    = w[i-16] ^ w[i-9] ^ rl(w[i-3], 15);
        w[i] = x ^ rl(x, 15) ^ rl(x, 23) ^ rl(w[i-13], 7) ^ w[i-6];
      end
      a = v[0]; b = v[1]; c = v[2]; d = v[3]; e = v[4]; f = v[5]; g = v[6]; h = v[7];
      for (int j = 0; j < 64; j++) begin
        tj  = (j < 16) ? 32'h79cc4519 : 32'h7a879d8a;
        ss1 = rl(rl(a, 12) + e + rl(tj, j), 7);
        ss2 = ss1 ^ rl(a, 12);
        tt1 = ((j < 16) ? (a ^ b ^ c) : ((a & b) | (a & c) | (b & c))) + d + ss2 + (w[j] ^ w[j+4]);
        tt2 = ((j < 16) ? (e ^ f ^ g) : ((e & f) | (~e & g))) + h + ss1 + w[j];
        d = c; c = rl(b, 9); b = a; a = tt1;
        h = g; g = rl(f, 19); f = e; e = tt2 ^ rl(tt2, 9) ^ rl(tt2, 17);
      end
      v[0] ^= a; v[1] ^= b; v[2] ^= c; v[3] ^= d;
      v[4] ^= e; v[5] ^= f; v[6] ^= g; v[7] ^= h;
    end
    return {v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]};
  endfunction

  function automatic bq_t rand_msg(input int n);
    bq_t q;
    for (int i = 0; i < n; i++) q.push_back(8'($urandom()));
    return q;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic run_msg(input bq_t m, input bit junk_keep, input string tag);
    int           sz  = m.size();
    int           nb  = (sz == 0) ? 1 : (sz + 63) / 64;
    int           rem = sz - 64 * (nb - 1);
    logic [255:0] exp = ref_hash(m);
    logic [255:0] held;
    for (int bk = 0; bk < nb; bk++) begin
      logic [511:0] d;
      logic [63:0]  k;
      bit           lst = (bk == nb - 1);
      int           wc;
      bit           rdy_bad;
      for (int i = 0; i < 16; i++) d[511-32*i -: 32] = $urandom();
      for (int i = 0; i < 64; i++) if (bk*64 + i < sz) d[511-8*i -: 8] = m[bk*64+i];
      if (lst) k = (rem == 64) ? '1 : ((64'd1 << rem) - 64'd1);
      else     k = junk_keep ? {$urandom(), $urandom()} : '1;
      wc = 0;
      @(negedge clk);
      while (!in_ready && wc < 300) begin @(negedge clk); wc++; end
      in_data = d; in_keep = k; in_last = lst; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      wc = 0;
      if (!lst) begin
        while (!in_ready && wc < 300) begin wc++; @(negedge clk); end
        chk({"R2 ready low cycles per block ", tag}, 256'(wc), 256'd32);
      end else begin
        rdy_bad = 1'b0;
        while (!dig_valid && wc < 300) begin
          if (in_ready) rdy_bad = 1'b1;
          wc++;
          @(negedge clk);
        end
        chk({"R5 digest latency ", tag}, 256'(wc), (rem >= 56) ? 256'd64 : 256'd32);
        chk({"R10 ready low until digest, high with it ", tag}, {254'd0, rdy_bad, in_ready}, 256'd1);
        chk(tag, dig_data, exp);
        held = dig_data;
        @(negedge clk);
        chk({"R6 strobe one cycle ", tag}, 256'(dig_valid), 256'd0);
        chk({"R6 digest held ", tag}, dig_data, held);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    bq_t m;
    int unsigned seed;
    seed     = $urandom(32'd20240611);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_keep  = '0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 256'(in_ready), 256'd1);
    chk("R1 strobe in reset", 256'(dig_valid), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 256'(in_ready), 256'd1);
    chk("R1 strobe after reset", 256'(dig_valid), 256'd0);

    m = {8'h61, 8'h62, 8'h63};
    chk("R3 bench model abc", ref_hash(m),
        256'h66c7f0f462eeedd9d1f2d46bdc10e4e24167c4875cf2f7a2297da02b8f4ba8e0);
    run_msg(m, 1'b0, "R3 abc");

    m = {};
    run_msg(m, 1'b0, "R9 empty message");

    run_msg(rand_msg(55), 1'b0, "R5 n=55");
    run_msg(rand_msg(56), 1'b0, "R5 n=56");
    run_msg(rand_msg(63), 1'b0, "R5 n=63");
    run_msg(rand_msg(64), 1'b0, "R5 n=64");
    run_msg(rand_msg(1),  1'b0, "R3 one byte");
    run_msg(rand_msg(65), 1'b0, "R4 65 bytes");
    run_msg(rand_msg(119), 1'b0, "R4 119 bytes");
    run_msg(rand_msg(120), 1'b0, "R4 120 bytes");
    run_msg(rand_msg(128), 1'b0, "R4 128 bytes");
    run_msg(rand_msg(150), 1'b1, "R8 junk keep 150 bytes");
    run_msg(rand_msg(192), 1'b1, "R8 junk keep 192 bytes");

    m = rand_msg(100);
    run_msg(m, 1'b0, "R7 first pass");
    run_msg(m, 1'b1, "R7 second pass");

    for (int r = 0; r < 10; r++) begin
      run_msg(rand_msg(int'($urandom() % 260)), 1'($urandom()), "R3 random");
    end

    summary();
    $finish;
  end

endmodule